// File: doc/BRIEF.md
# Width-Aware Register Read Checker

This block sits on the read path of one protected register. Each stored entry is a 32-bit word plus a 3-bit format tag. The tag records how wide the stored value is, and so how many of the word's spare upper bits were used for check bits when the entry was written. On a read, the block regenerates the check bits that the tag calls for and compares them with the stored ones. It then returns the value with any correctable flip undone, together with three flags: error seen, error corrected, and error beyond repair.

A narrow value of up to 15 bits is split into three interleaved groups. Each group carries its own Hamming check and overall parity, so one flip per group can be repaired. That means a burst of three adjacent flips is corrected. A 26-bit value carries a single Hamming code plus parity and corrects one flip. A full 32-bit value has no spare bits in the word, so two interleaved parity bits are kept in the tag, and those only detect. The result is registered and appears one cycle after the read.

Top module: `width_ecc_reader`

## Requirements
- R1: `out_valid` equals `rd_valid` delayed by one clock. While `out_valid` is low, all three flags are low. Reset clears `out_valid` and all flags.
- R2: Tag encodings: 000 is the 15-bit format, 001 is the 26-bit format, 1xx is the full format, and 010 and 011 are undefined. Narrow results are zero-extended, so stored check bits never appear in `out_data`. In the 15-bit format, word bits 31:30 are ignored.
- R3: 15-bit format layout. Group g (0..2) holds element k at data bit g+3k. Its check field is at bits 15+5g up to 19+5g: the low four bits are Hamming checks for codeword positions 1, 2, 4 and 8, and the top bit is the even parity of the group's data and checks. Elements 0..4 sit at codeword positions 3, 5, 6, 7 and 9. The check value is the XOR of the positions of the set elements. One flip per group is corrected, so any run of three adjacent data flips is repaired with `corr_flag` set.
- R4: In a group, a nonzero syndrome with matching parity is uncorrectable. The result is `uncorr_flag` set and that group's data left as stored.
- R5: A zero syndrome with a parity mismatch, or a syndrome that names a Hamming check position, is reported as corrected, and no data bit changes.
- R6: 26-bit format layout. Data bit i sits at the i-th non-power-of-two position in 1..31. Bits 30:26 hold the check value, the XOR of the positions of the set data bits. Bit 31 holds the even parity over data and check. Any single flip among the 32 bits is corrected.
- R7: In the 26-bit format, two flips give `err_flag` and `uncorr_flag` set, `corr_flag` clear, and the data left as stored.
- R8: Full format. Tag bit 0 is the parity of the even-indexed word bits, and tag bit 1 is the parity of the odd-indexed ones. A mismatch raises `err_flag` and `uncorr_flag`. `corr_flag` is never set, and the word passes through unchanged.
- R9: An undefined tag raises `err_flag` and `uncorr_flag` and returns zero data.
- R10: `corr_flag` and `uncorr_flag` are never both set. `err_flag` equals their OR. A word that matches its check bits raises no flag.
- R11: In a 15-bit group, a syndrome of 10..15 points past the codeword. It changes no data bit and is reported as uncorrectable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | A read is presented this cycle |
| rd_word | input | 32 | Stored word being read |
| rd_tag | input | 3 | Stored format tag |
| out_valid | output | 1 | Result valid, one cycle after `rd_valid` |
| out_data | output | 32 | Repaired, zero-extended value |
| err_flag | output | 1 | Any check mismatch |
| corr_flag | output | 1 | All mismatches were repaired |
| uncorr_flag | output | 1 | At least one mismatch could not be repaired |

## Verification
A wrong syndrome or a wrong decoder mapping shows on the cycle after the read. It appears either as an inverted data bit at a position that differs from the injected one, or as a clean word reported with a flag. A wrong group split or a wrong check-field offset shows up when the bench sweeps single, double and burst flips across every bit. Misclassifying a group flips the pair `corr_flag`/`uncorr_flag` on that same cycle. Each of these cases is compared against an independent behavioural decoder.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int WORD_W  = 32;
  localparam int TAG_W   = 3;
  localparam int GROUPS  = 3;
  localparam int GRP_DW  = 5;
  localparam int GRP_CW  = 4;
  localparam int N15_W   = GROUPS * GRP_DW;
  localparam int N26_DW  = 26;
  localparam int N26_CW  = 5;
  localparam int MAX_DW  = 26;
  localparam logic [TAG_W-1:0] FMT_N15 = 3'b000;
  localparam logic [TAG_W-1:0] FMT_N26 = 3'b001;

  function automatic bit is_pow2(input int p);
    return (p != 0) && ((p & (p - 1)) == 0);
  endfunction

  // codeword position of the idx-th data element (skips check positions)
  function automatic int data_pos(input int idx);
    int pos;
    int cnt;
    pos = -1;
    cnt = 0;
    for (int p = 1; p < 64; p++) begin
      if (!is_pow2(p)) begin
        if (cnt == idx && pos < 0) pos = p;
        cnt++;
      end
    end
    return pos;
  endfunction

  // Hamming check value: XOR of positions of set data elements
  function automatic logic [4:0] ham_chk(input logic [MAX_DW-1:0] d, input int n);
    logic [4:0] acc;
    acc = '0;
    for (int i = 0; i < MAX_DW; i++)
      if (i < n && d[i]) acc ^= 5'(data_pos(i));
    return acc;
  endfunction
endpackage

// File: rtl/grp_decoder.sv
module grp_decoder #(
  parameter int DATA_W = 5,
  parameter int CHK_W  = 4
) (
  input  logic [DATA_W-1:0] data_in,
  input  logic [CHK_W-1:0]  chk_in,
  input  logic              par_in,
  output logic [DATA_W-1:0] data_out,
  output logic              grp_err,
  output logic              grp_fix,
  output logic              grp_bad
);
  import ecc_pkg::*;
  localparam int NPOS     = 1 << CHK_W;
  localparam int LAST_POS = DATA_W + CHK_W;
  localparam logic [CHK_W:0] LAST = LAST_POS[CHK_W:0];

  logic [4:0]        calc;
  logic [CHK_W-1:0]  syn;
  logic              par_mis, syn_nz, in_range, single, fix_here;
  logic [NPOS-1:0]   hot;
  logic [DATA_W-1:0] flip;

  assign calc     = ham_chk(MAX_DW'(data_in), DATA_W);
  assign syn      = calc[CHK_W-1:0] ^ chk_in;
  assign par_mis  = ^{par_in, chk_in, data_in};
  assign syn_nz   = |syn;
  assign in_range = ({1'b0, syn} <= LAST);
  assign single   = syn_nz & par_mis;
  assign fix_here = single & in_range;

  // one-hot decode of the syndrome
  always_comb begin
    hot = '0;
    if (fix_here) hot[syn] = 1'b1;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_flip
    localparam int P = data_pos(i);
    assign flip[i] = hot[P];
  end

  assign data_out = data_in ^ flip;
  assign grp_err  = syn_nz | par_mis;
  assign grp_fix  = fix_here | (!syn_nz & par_mis);
  assign grp_bad  = (syn_nz & !par_mis) | (single & !in_range);
endmodule

// File: rtl/parity_pair.sv
module parity_pair #(
  parameter int WIDTH = 32,
  parameter int LANES = 2
) (
  input  logic [WIDTH-1:0] word,
  input  logic [LANES-1:0] stored,
  output logic [LANES-1:0] mism
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      mism[l] = stored[l];
      for (int b = l; b < WIDTH; b += LANES) mism[l] ^= word[b];
    end
  end
endmodule

// File: rtl/width_ecc_reader.sv
module width_ecc_reader
  import ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] rd_word,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              err_flag,
  output logic              corr_flag,
  output logic              uncorr_flag
);
  localparam int GSTEP = GRP_CW + 1;

  logic [GRP_DW-1:0] g_din  [GROUPS];
  logic [GRP_DW-1:0] g_dout [GROUPS];
  logic [GROUPS-1:0] g_err, g_fix, g_bad;
  logic [N15_W-1:0]  n15_fix;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    for (genvar k = 0; k < GRP_DW; k++) begin : g_el
      assign g_din[g][k]           = rd_word[g + GROUPS*k];
      assign n15_fix[g + GROUPS*k] = g_dout[g][k];
    end
    grp_decoder #(.DATA_W(GRP_DW), .CHK_W(GRP_CW)) u_grp (
      .data_in (g_din[g]),
      .chk_in  (rd_word[N15_W + g*GSTEP +: GRP_CW]),
      .par_in  (rd_word[N15_W + g*GSTEP + GRP_CW]),
      .data_out(g_dout[g]),
      .grp_err (g_err[g]),
      .grp_fix (g_fix[g]),
      .grp_bad (g_bad[g])
    );
  end

  logic [N26_DW-1:0] w_fix;
  logic              w_err, w_fix_f, w_bad;
  grp_decoder #(.DATA_W(N26_DW), .CHK_W(N26_CW)) u_wide (
    .data_in (rd_word[N26_DW-1:0]),
    .chk_in  (rd_word[N26_DW +: N26_CW]),
    .par_in  (rd_word[WORD_W-1]),
    .data_out(w_fix),
    .grp_err (w_err),
    .grp_fix (w_fix_f),
    .grp_bad (w_bad)
  );

  logic [1:0] f_mism;
  parity_pair #(.WIDTH(WORD_W), .LANES(2)) u_full (
    .word  (rd_word),
    .stored(rd_tag[1:0]),
    .mism  (f_mism)
  );

  logic [WORD_W-1:0] nx_data;
  logic              nx_err, nx_fix, nx_bad;

  always_comb begin
    nx_data = '0;
    nx_err  = 1'b1;
    nx_bad  = 1'b1;
    nx_fix  = 1'b0;
    if (rd_tag[2]) begin
      nx_data = rd_word;
      nx_err  = |f_mism;
      nx_bad  = |f_mism;
    end else if (rd_tag == FMT_N15) begin
      nx_data = WORD_W'(n15_fix);
      nx_err  = |g_err;
      nx_bad  = |g_bad;
      nx_fix  = (|g_err) & ~(|g_bad);
    end else if (rd_tag == FMT_N26) begin
      nx_data = WORD_W'(w_fix);
      nx_err  = w_err;
      nx_bad  = w_bad;
      nx_fix  = w_err & ~w_bad;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      err_flag    <= 1'b0;
      corr_flag   <= 1'b0;
      uncorr_flag <= 1'b0;
    end else begin
      out_valid   <= rd_valid;
      out_data    <= nx_data;
      err_flag    <= rd_valid & nx_err;
      corr_flag   <= rd_valid & nx_fix;
      uncorr_flag <= rd_valid & nx_bad;
    end
  end

  // R1
  lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> out_valid);
  // R1
  lat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !out_valid);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(err_flag || corr_flag || uncorr_flag));
  // R10
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(corr_flag && uncorr_flag));
  // R10
  flag_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (err_flag == (corr_flag || uncorr_flag)));
  // R2
  n15_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_tag == FMT_N15) |=> (out_data[WORD_W-1:N15_W] == '0));
  // R2
  n26_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_tag == FMT_N26) |=> (out_data[WORD_W-1:N26_DW] == '0));
  // R8
  full_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_tag[2]) |=> (!corr_flag && out_data == $past(rd_word)));
  // R9
  badtag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_tag[2] && rd_tag[1]) |=> (uncorr_flag && out_data == '0));
  // R4
  for (genvar g = 0; g < GROUPS; g++) begin : g_part
    grp_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ($onehot0({g_fix[g], g_bad[g]}) && (g_err[g] == (g_fix[g] || g_bad[g]))));
  end
  // R7
  wide_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($onehot0({w_fix_f, w_bad}) && (w_err == (w_fix_f || w_bad))));
endmodule

// File: tb/tb_width_ecc_reader.sv
module tb_width_ecc_reader;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_valid;
  logic [31:0] rd_word;
  logic [2:0]  rd_tag;
  logic        out_valid, err_flag, corr_flag, uncorr_flag;
  logic [31:0] out_data;

  always #5 clk = ~clk;

  width_ecc_reader dut (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_word(rd_word), .rd_tag(rd_tag),
    .out_valid(out_valid), .out_data(out_data), .err_flag(err_flag),
    .corr_flag(corr_flag), .uncorr_flag(uncorr_flag)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;
  logic        exp_v = 1'b0;
  logic [31:0] exp_d = '0;
  logic        exp_e = 1'b0, exp_c = 1'b0, exp_u = 1'b0;
  string       exp_req = "R1";

  function automatic bit pw2(input int p);
    return p > 0 && (p & (p - 1)) == 0;
  endfunction

  function automatic logic [31:0] spread(input logic [31:0] d, input int n);
    logic [31:0] cw = '0;
    int j = 0;
    for (int p = 1; p <= n; p++)
      if (!pw2(p)) begin cw[p] = d[j]; j++; end
    return cw;
  endfunction

  function automatic logic [31:0] gather(input logic [31:0] cw, input int n);
    logic [31:0] d = '0;
    int j = 0;
    for (int p = 1; p <= n; p++)
      if (!pw2(p)) begin d[j] = cw[p]; j++; end
    return d;
  endfunction

  function automatic int syn_of(input logic [31:0] cw, input int n);
    int s = 0;
    for (int p = 1; p <= n; p++) if (cw[p]) s = s ^ p;
    return s;
  endfunction

  function automatic logic [31:0] enc15(input logic [14:0] v);
    logic [31:0] w = {17'b0, v};
    for (int g = 0; g < 3; g++) begin
      logic [31:0] d = '0;
      logic [31:0] cw;
      int s;
      for (int k = 0; k < 5; k++) d[k] = v[g + 3*k];
      cw = spread(d, 9);
      s = syn_of(cw, 9);
      for (int i = 0; i < 4; i++) w[15 + 5*g + i] = s[i];
      w[19 + 5*g] = (^cw) ^ (^s[3:0]);
    end
    return w;
  endfunction

  function automatic logic [31:0] enc26(input logic [25:0] v);
    logic [31:0] cw = spread({6'b0, v}, 31);
    int s = syn_of(cw, 31);
    return {(^cw) ^ (^s[4:0]), s[4:0], v};
  endfunction

  function automatic logic [2:0] tagfull(input logic [31:0] w);
    logic ev = 0, od = 0;
    for (int b = 0; b < 32; b++) if (b % 2 == 0) ev ^= w[b]; else od ^= w[b];
    return {1'b1, od, ev};
  endfunction

  task automatic dec_grp(input logic [31:0] d, input logic [4:0] chk, input logic par,
                         input int n, output logic [31:0] dout, output bit e, output bit f, output bit b);
    logic [31:0] cw = spread(d, n);
    int s;
    bit pm;
    for (int i = 0; i < 5; i++) if ((1 << i) <= n) cw[1 << i] = chk[i];
    s  = syn_of(cw, n);
    pm = (^cw) ^ par;
    e = (s != 0) || pm; f = 0; b = 0;
    if (s != 0 && pm && s <= n) begin cw[s] = ~cw[s]; f = 1; end
    else if (s == 0 && pm) f = 1;
    else if (s != 0) b = 1;
    dout = gather(cw, n);
  endtask

  task automatic ref_dec(input logic [31:0] w, input logic [2:0] t,
                         output logic [31:0] d, output logic e, output logic c, output logic u);
    logic [31:0] go;
    bit ge, gf, gb;
    d = '0; e = 1; u = 1; c = 0;
    if (t[2]) begin
      logic [2:0] tf = tagfull(w);
      d = w; e = (tf[1:0] != t[1:0]); u = e;
    end else if (t == 3'b000) begin
      bit any_e = 0, any_b = 0;
      for (int g = 0; g < 3; g++) begin
        logic [31:0] gd = '0;
        for (int k = 0; k < 5; k++) gd[k] = w[g + 3*k];
        dec_grp(gd, {1'b0, w[15+5*g +: 4]}, w[19+5*g], 9, go, ge, gf, gb);
        for (int k = 0; k < 5; k++) d[g + 3*k] = go[k];
        any_e |= ge; any_b |= gb;
      end
      e = any_e; u = any_b; c = any_e && !any_b;
    end else if (t == 3'b001) begin
      dec_grp({6'b0, w[25:0]}, w[30:26], w[31], 31, go, ge, gf, gb);
      d = {6'b0, go[25:0]}; e = ge; u = gb; c = ge && !gb;
    end
  endtask

  task automatic compare();
    bit bad = 0;
    n_cmp++;
    if (out_valid !== exp_v) bad = 1;
    else if (exp_v && (out_data !== exp_d || err_flag !== exp_e || corr_flag !== exp_c || uncorr_flag !== exp_u)) bad = 1;
    else if (!exp_v && (err_flag !== 1'b0 || corr_flag !== 1'b0 || uncorr_flag !== 1'b0)) bad = 1;
    if (bad) begin
      n_bad++;
      $display("FAIL %s: got v=%b d=%h e=%b c=%b u=%b, expected v=%b d=%h e=%b c=%b u=%b",
               exp_req, out_valid, out_data, err_flag, corr_flag, uncorr_flag,
               exp_v, exp_d, exp_e, exp_c, exp_u);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] w, input logic [2:0] t, input string req);
    @(negedge clk);
    compare();
    rd_valid = v; rd_word = w; rd_tag = t;
    exp_v = v; exp_req = req;
    if (v) ref_dec(w, t, exp_d, exp_e, exp_c, exp_u);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no finish, expected end of stimulus");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    rst_n = 0; rd_valid = 0; rd_word = '0; rd_tag = '0;
    // R1 reset state
    repeat (3) begin @(negedge clk); compare(); end
    rst_n = 1;
    step(0, 32'hFFFF_FFFF, 3'b000, "R1");
    // R10 clean words, R2 zero-extension
    step(1, enc15(15'h0000), 3'b000, "R10");
    step(1, enc15(15'h7FFF), 3'b000, "R10");
    step(1, enc15(15'h2A5A), 3'b000, "R2");
    step(1, enc15(15'h1234) | 32'hC000_0000, 3'b000, "R2");
    step(1, enc26(26'h0), 3'b001, "R10");
    step(1, enc26(26'h3FF_FFFF), 3'b001, "R2");
    step(1, enc26(26'h15A_C3E1), 3'b001, "R2");
    step(0, '0, 3'b000, "R1");
    w = 32'hDEAD_BEEF;
    step(1, w, tagfull(w), "R8");
    // R3 single flips in each data bit, R5 check/parity flips
    for (int b = 0; b < 30; b++)
      step(1, enc15(15'h5B3C) ^ (32'h1 << b), 3'b000, b < 15 ? "R3" : "R5");
    // R3 three adjacent flips, one per group
    for (int s = 0; s < 13; s++)
      step(1, enc15(15'h6E91) ^ (32'h7 << s), 3'b000, "R3");
    // R4 two flips in one group
    for (int b = 0; b < 12; b++)
      step(1, enc15(15'h3C0F) ^ (32'h9 << b), 3'b000, "R4");
    // R11 syndrome past the codeword (positions 3,5,9)
    for (int g = 0; g < 3; g++)
      step(1, enc15(15'h4B27) ^ (32'h1 << g) ^ (32'h1 << (g+3)) ^ (32'h1 << (g+12)), 3'b000, "R11");
    // R6 single flips anywhere in the 26-bit format
    for (int b = 0; b < 32; b++)
      step(1, enc26(26'h2B7_91C4) ^ (32'h1 << b), 3'b001, "R6");
    // R7 double flips
    for (int b = 0; b < 31; b++)
      step(1, enc26(26'h0C3_5A96) ^ (32'h3 << b), 3'b001, "R7");
    // R8 full format detection only
    for (int b = 0; b < 32; b += 5) begin
      w = $urandom;
      step(1, w ^ (32'h1 << b), tagfull(w), "R8");
      step(1, w ^ (32'h3 << (b % 31)), tagfull(w), "R8");
      step(1, w, tagfull(w) ^ 3'b001, "R8");
    end
    // R9 undefined tags
    step(1, 32'hFFFF_FFFF, 3'b010, "R9");
    step(1, enc26(26'h123), 3'b011, "R9");
    // R10 random mix
    for (int i = 0; i < 300; i++) begin
      int fmt = $urandom_range(0, 3);
      int nf  = $urandom_range(0, 3);
      logic [31:0] r = $urandom;
      logic [2:0]  t;
      if (fmt == 0) begin w = enc15(r[14:0]); t = 3'b000; end
      else if (fmt == 1) begin w = enc26(r[25:0]); t = 3'b001; end
      else if (fmt == 2) begin w = r; t = tagfull(r); end
      else begin w = r; t = {1'b0, 1'b1, r[0]}; end
      for (int f = 0; f < nf; f++) w[$urandom_range(0, 31)] ^= 1'b1;
      step($urandom_range(0, 4) != 0, w, t, "R10");
    end
    step(0, '0, 3'b000, "R1");
    step(0, '0, 3'b000, "R1");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule